// File: doc/BRIEF.md
# Nonvolatile Byte Store Loader

This block keeps a volatile shadow array of 256 bytes in step with a 256-byte nonvolatile store. When reset is released it copies every byte of the store into the shadow array on its own. While copying, it sums a fixed range of bytes and compares the low eight bits of that sum with a reference byte kept in the store. Later, a 16-bit control register starts one of three commands: a full reload, a single-byte read into the shadow array, or a single-byte write-through from the shadow array into the store.

Software may write shadow bytes directly. Such writes change only the volatile copy. A reload overwrites them. The only way to change the store is to write the shadow byte first and then issue a single-byte write-through. The store is reached through a request channel with valid/ready handshake and a response channel. A request stays stable until ready is seen. Read data returns on the response channel after any delay. The block always takes a response and applies no back-pressure to it.

Top module: `nvm_loader`

## Requirements
- R1: From reset, busy is high and an upload runs by itself. It issues read requests for addresses 0 to 255 in ascending order, with one read outstanding at a time. Busy falls in the cycle after the response for address 255 is taken.
- R2: Every byte returned for an upload or a single-byte read is written into the shadow array at the address it was read from.
- R3: At the end of each upload, the checksum output holds the low 8 bits of the sum of bytes 0 to 117. The pass flag is 1 when that value equals byte 118 and 0 when it does not. Both outputs are 0 from reset until the first upload ends, and they change at no other time.
- R4: A control write with bits 1:0 = 10 and bit 5 = 0 reads the store byte at the address in bits 15:8 into the shadow array at the same address.
- R5: A control write with bits 1:0 = 10 and bit 5 = 1 issues one write request. Its address comes from bits 15:8 and its data is the shadow byte at that address. No response is awaited: busy falls in the cycle after the request is accepted.
- R6: A control write with bits 1:0 = 11 and bit 5 = 0 starts a full upload that behaves as in R1, R2 and R3.
- R7: Control reads return the last accepted control value. Bits 1:0 return to 00 in the same cycle that busy falls.
- R8: A control write made while busy is ignored. The register keeps its value and no further command is started.
- R9: A control write with bits 1:0 = 00 or 01, or with 11 and bit 5 = 1, starts nothing. The value is stored with bits 1:0 forced to 00 and busy stays low.
- R10: A direct shadow write takes effect only while idle and is ignored while busy. It never reaches the store, so a later upload replaces it with the stored byte.
- R11: A request held without ready keeps valid, address, write flag and write data unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 16 | Control value: [15:8] byte address, [5] direction, [1:0] command |
| ctl_rd_data | output | 16 | Current control register value |
| busy | output | 1 | A command or the boot upload is in progress |
| cks_calc | output | 8 | Checksum computed by the last completed upload |
| cks_ok | output | 1 | Checksum matched the reference byte |
| shd_wr_en | input | 1 | Direct shadow byte write strobe |
| shd_wr_addr | input | 8 | Direct shadow write address |
| shd_wr_data | input | 8 | Direct shadow write data |
| shd_rd_addr | input | 8 | Shadow read address |
| shd_rd_data | output | 8 | Shadow byte at shd_rd_addr (combinational) |
| nvm_req_valid | output | 1 | Store request valid |
| nvm_req_ready | input | 1 | Store accepts the request |
| nvm_req_we | output | 1 | Request is a write |
| nvm_req_addr | output | 8 | Request byte address |
| nvm_req_wdata | output | 8 | Request write data |
| nvm_rsp_valid | input | 1 | Read response valid |
| nvm_rsp_data | input | 8 | Read response byte |

## Verification
The hardest states to reach from the ports are those where software acts while a command runs. Examples are a control write or a direct shadow write that lands in the middle of an upload, and a write-through request held back by the store. The bench's store model stalls ready at random and returns read data after a random delay of one to three cycles, so requests sit held and responses arrive at varying points. The bench also issues ignored control and shadow writes during the boot upload and during a forced reload. It reaches the checksum mismatch on purpose: it corrupts the reference byte with a shadow write followed by a write-through, then reloads.

// File: rtl/nvm_loader_pkg.sv
package nvm_loader_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} seq_state_e;
  typedef enum logic [1:0] {OP_UPLOAD, OP_RD1, OP_WR1} seq_op_e;
  localparam logic [1:0] CMD_SINGLE = 2'b10;
  localparam logic [1:0] CMD_RELOAD = 2'b11;
  localparam int         DIR_BIT    = 5;
  localparam int         CTL_W      = 16;
  localparam int         ADDR_LSB   = 8;
endpackage

// File: rtl/nvm_loader_shadow.sv
module nvm_loader_shadow #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [7:0]    ld_data_i,
  input  logic          sw_we_i,
  input  logic [AW-1:0] sw_addr_i,
  input  logic [7:0]    sw_data_i,
  input  logic [AW-1:0] rd_a_addr_i,
  output logic [7:0]    rd_a_data_o,
  input  logic [AW-1:0] rd_b_addr_i,
  output logic [7:0]    rd_b_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ld_we_i) begin
      mem[ld_addr_i] <= ld_data_i;
    end else if (sw_we_i && !busy_i) begin
      mem[sw_addr_i] <= sw_data_i;
    end
  end

  assign rd_a_data_o = mem[rd_a_addr_i];
  assign rd_b_data_o = mem[rd_b_addr_i];

  // R10: a direct write during a command leaves the byte untouched
  a_r10_busy_drops_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && sw_we_i && !ld_we_i) |=> (mem[$past(sw_addr_i)] == $past(mem[sw_addr_i])));
endmodule

// File: rtl/nvm_loader_cksum.sv
module nvm_loader_cksum #(
  parameter int AW       = 8,
  parameter int SUM_LAST = 117,
  parameter int REF_POS  = 118
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          byte_vld_i,
  input  logic [AW-1:0] byte_idx_i,
  input  logic [7:0]    byte_val_i,
  input  logic          fin_i,
  output logic [7:0]    calc_o,
  output logic          ok_o
);
  localparam logic [AW-1:0] LAST_A = AW'(SUM_LAST);
  localparam logic [AW-1:0] REF_A  = AW'(REF_POS);

  logic [7:0] sum_q, sum_nxt, ref_q, ref_nxt;

  always_comb begin
    sum_nxt = sum_q;
    ref_nxt = ref_q;
    if (byte_vld_i) begin
      if (byte_idx_i <= LAST_A) sum_nxt = sum_q + byte_val_i;
      if (byte_idx_i == REF_A)  ref_nxt = byte_val_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q  <= '0;
      ref_q  <= '0;
      calc_o <= '0;
      ok_o   <= 1'b0;
    end else begin
      if (clr_i) begin
        sum_q <= '0;
        ref_q <= '0;
      end else begin
        sum_q <= sum_nxt;
        ref_q <= ref_nxt;
      end
      if (fin_i) begin
        calc_o <= sum_nxt;
        ok_o   <= (sum_nxt == ref_nxt);
      end
    end
  end

  // R3: published results move only at the end of an upload
  a_r3_publish_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> ($stable(calc_o) && $stable(ok_o)));
endmodule

// File: rtl/nvm_loader_seq.sv
module nvm_loader_seq
  import nvm_loader_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_q_o,
  output logic             busy_o,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic             req_we_o,
  output logic [AW-1:0]    req_addr_o,
  output logic [7:0]       req_wdata_o,
  input  logic             rsp_valid_i,
  input  logic [7:0]       rsp_data_i,
  input  logic [7:0]       shd_byte_i,
  output logic             ld_we_o,
  output logic [AW-1:0]    ld_addr_o,
  output logic [7:0]       ld_data_o,
  output logic             ck_clr_o,
  output logic             ck_vld_o,
  output logic [AW-1:0]    ck_idx_o,
  output logic             ck_fin_o
);
  localparam logic [AW-1:0] LAST_IDX = '1;

  seq_state_e    state_q;
  seq_op_e       op_q;
  logic [AW-1:0] idx_q;
  logic [AW-1:0] ctl_addr;
  logic          cmd_ok, cmd_reload, accept;

  assign ctl_addr   = ctl_q_o[ADDR_LSB +: AW];
  assign cmd_reload = (ctl_wdata_i[1:0] == CMD_RELOAD) && !ctl_wdata_i[DIR_BIT];
  assign cmd_ok     = (ctl_wdata_i[1:0] == CMD_SINGLE) || cmd_reload;
  assign accept     = ctl_we_i && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_REQ;
      op_q    <= OP_UPLOAD;
      idx_q   <= '0;
      ctl_q_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          ctl_q_o <= cmd_ok ? ctl_wdata_i : {ctl_wdata_i[CTL_W-1:2], 2'b00};
          if (cmd_ok) begin
            state_q <= ST_REQ;
            idx_q   <= '0;
            op_q    <= cmd_reload ? OP_UPLOAD :
                       (ctl_wdata_i[DIR_BIT] ? OP_WR1 : OP_RD1);
          end
        end
        ST_REQ: if (req_ready_i) begin
          if (op_q == OP_WR1) begin
            state_q      <= ST_IDLE;
            ctl_q_o[1:0] <= 2'b00;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (rsp_valid_i) begin
          if (op_q == OP_UPLOAD && idx_q != LAST_IDX) begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_REQ;
          end else begin
            state_q      <= ST_IDLE;
            ctl_q_o[1:0] <= 2'b00;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign req_valid_o = (state_q == ST_REQ);
  assign req_we_o    = (op_q == OP_WR1);
  assign req_addr_o  = (op_q == OP_UPLOAD) ? idx_q : ctl_addr;
  assign req_wdata_o = shd_byte_i;

  assign ld_we_o   = (state_q == ST_WAIT) && rsp_valid_i;
  assign ld_addr_o = req_addr_o;
  assign ld_data_o = rsp_data_i;

  assign ck_clr_o = accept && cmd_reload;
  assign ck_vld_o = ld_we_o && (op_q == OP_UPLOAD);
  assign ck_idx_o = idx_q;
  assign ck_fin_o = ck_vld_o && (idx_q == LAST_IDX);

  // R11: a stalled request holds all of its fields
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_we_o) && $stable(req_wdata_o)));

  // R7: a pending command code is visible only while busy
  a_r7_cmd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q_o[1:0] != 2'b00) |-> busy_o);

  // R8: control writes during a command leave the register alone
  a_r8_ctl_kept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ctl_we_i) |=> (ctl_q_o[CTL_W-1:2] == $past(ctl_q_o[CTL_W-1:2])));

  // R1: responses only arrive while a read is outstanding
  a_r1_rsp_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_i |-> (state_q == ST_WAIT));
endmodule

// File: rtl/nvm_loader.sv
module nvm_loader
  import nvm_loader_pkg::*;
#(
  parameter int AW       = 8,
  parameter int SUM_LAST = 117,
  parameter int REF_POS  = 118
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  output logic [CTL_W-1:0] ctl_rd_data,
  output logic             busy,
  output logic [7:0]       cks_calc,
  output logic             cks_ok,
  input  logic             shd_wr_en,
  input  logic [AW-1:0]    shd_wr_addr,
  input  logic [7:0]       shd_wr_data,
  input  logic [AW-1:0]    shd_rd_addr,
  output logic [7:0]       shd_rd_data,
  output logic             nvm_req_valid,
  input  logic             nvm_req_ready,
  output logic             nvm_req_we,
  output logic [AW-1:0]    nvm_req_addr,
  output logic [7:0]       nvm_req_wdata,
  input  logic             nvm_rsp_valid,
  input  logic [7:0]       nvm_rsp_data
);
  logic          ld_we, ck_clr, ck_vld, ck_fin;
  logic [AW-1:0] ld_addr, ck_idx;
  logic [7:0]    ld_data, shd_b;

  nvm_loader_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ctl_we_i(ctl_wr_en), .ctl_wdata_i(ctl_wr_data), .ctl_q_o(ctl_rd_data),
    .busy_o(busy),
    .req_valid_o(nvm_req_valid), .req_ready_i(nvm_req_ready), .req_we_o(nvm_req_we),
    .req_addr_o(nvm_req_addr), .req_wdata_o(nvm_req_wdata),
    .rsp_valid_i(nvm_rsp_valid), .rsp_data_i(nvm_rsp_data),
    .shd_byte_i(shd_b),
    .ld_we_o(ld_we), .ld_addr_o(ld_addr), .ld_data_o(ld_data),
    .ck_clr_o(ck_clr), .ck_vld_o(ck_vld), .ck_idx_o(ck_idx), .ck_fin_o(ck_fin)
  );

  nvm_loader_shadow #(.AW(AW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .busy_i(busy),
    .ld_we_i(ld_we), .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .sw_we_i(shd_wr_en), .sw_addr_i(shd_wr_addr), .sw_data_i(shd_wr_data),
    .rd_a_addr_i(shd_rd_addr), .rd_a_data_o(shd_rd_data),
    .rd_b_addr_i(ctl_rd_data[ADDR_LSB +: AW]), .rd_b_data_o(shd_b)
  );

  nvm_loader_cksum #(.AW(AW), .SUM_LAST(SUM_LAST), .REF_POS(REF_POS)) u_cksum (
    .clk(clk), .rst_n(rst_n), .clr_i(ck_clr),
    .byte_vld_i(ck_vld), .byte_idx_i(ck_idx), .byte_val_i(ld_data),
    .fin_i(ck_fin), .calc_o(cks_calc), .ok_o(cks_ok)
  );
endmodule

// File: tb/nvm_loader_tb.sv
module nvm_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [15:0] ctl_wr_data = '0;
  logic [15:0] ctl_rd_data;
  logic        busy;
  logic [7:0]  cks_calc;
  logic        cks_ok;
  logic        shd_wr_en = 1'b0;
  logic [7:0]  shd_wr_addr = '0, shd_wr_data = '0, shd_rd_addr = '0, shd_rd_data;
  logic        nvm_req_valid, nvm_req_we;
  logic        nvm_req_ready = 1'b0;
  logic [7:0]  nvm_req_addr, nvm_req_wdata;
  logic        nvm_rsp_valid = 1'b0;
  logic [7:0]  nvm_rsp_data = '0;

  always #10 clk = ~clk;

  nvm_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ctl_rd_data(ctl_rd_data), .busy(busy), .cks_calc(cks_calc), .cks_ok(cks_ok),
    .shd_wr_en(shd_wr_en), .shd_wr_addr(shd_wr_addr), .shd_wr_data(shd_wr_data),
    .shd_rd_addr(shd_rd_addr), .shd_rd_data(shd_rd_data),
    .nvm_req_valid(nvm_req_valid), .nvm_req_ready(nvm_req_ready), .nvm_req_we(nvm_req_we),
    .nvm_req_addr(nvm_req_addr), .nvm_req_wdata(nvm_req_wdata),
    .nvm_rsp_valid(nvm_rsp_valid), .nvm_rsp_data(nvm_rsp_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] nvm_mem [256];
  logic [7:0] m_shd [256];
  logic        m_busy = 1'b1, m_ok = 1'b0;
  logic [15:0] m_ctl = '0;
  logic [7:0]  m_calc = '0, m_idx = '0, m_addr = '0;
  int          m_op = 0;                // 0 upload, 1 single read, 2 single write
  logic        pend = 1'b0, prev_stall = 1'b0, cur_busy;
  logic [7:0]  p_addr = '0;
  int          p_cnt = 0;
  logic [17:0] prev_req = '0;
  logic        probe_on = 1'b0;
  logic [7:0]  probe_addr = '0, sweep = '0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] sum_range();
    logic [7:0] s = '0;
    for (int i = 0; i <= 117; i++) s = s + nvm_mem[i];
    return s;
  endfunction

  // behavioural reference, evaluated each cycle away from the clock edge
  always begin
    @(negedge clk); #2;
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired (R1 progress)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    check("R1 busy", busy, m_busy);
    check("R7 ctl readback", ctl_rd_data, m_ctl);
    check("R3 checksum value", cks_calc, m_calc);
    check("R3 checksum pass", cks_ok, m_ok);
    check("R2 shadow byte", shd_rd_data, m_shd[shd_rd_addr]);
    if (prev_stall)
      check("R11 held request", {nvm_req_valid, nvm_req_we, nvm_req_addr, nvm_req_wdata}, prev_req);
    if (rst_n && nvm_req_valid) begin
      check("R1 request address", nvm_req_addr, (m_op == 0) ? m_idx : m_addr);
      check("R5 request kind", nvm_req_we, (m_op == 2));
      if (m_op == 2) check("R5 write data", nvm_req_wdata, m_shd[m_addr]);
    end
    cur_busy = m_busy;
    if (!rst_n) begin
      m_busy = 1'b1; m_ctl = '0; m_calc = '0; m_ok = 1'b0; m_idx = '0; m_op = 0;
      for (int i = 0; i < 256; i++) m_shd[i] = '0;
      pend = 1'b0; prev_stall = 1'b0; nvm_rsp_valid = 1'b0; nvm_req_ready = 1'b0;
    end else begin
      nvm_rsp_valid = 1'b0;
      if (pend) begin
        p_cnt--;
        if (p_cnt == 0) begin
          pend = 1'b0;
          nvm_rsp_valid = 1'b1;
          nvm_rsp_data = nvm_mem[p_addr];
          m_shd[p_addr] = nvm_mem[p_addr];
          if (m_op == 0 && p_addr != 8'hFF) m_idx = m_idx + 1'b1;
          else begin
            m_busy = 1'b0; m_ctl[1:0] = 2'b00;
            if (m_op == 0) begin m_calc = sum_range(); m_ok = (m_calc == nvm_mem[118]); end
          end
        end
      end
      nvm_req_ready = ($urandom % 4) != 0;
      prev_stall = nvm_req_valid && !nvm_req_ready;
      prev_req = {nvm_req_valid, nvm_req_we, nvm_req_addr, nvm_req_wdata};
      if (nvm_req_valid && nvm_req_ready) begin
        if (nvm_req_we) begin
          nvm_mem[nvm_req_addr] = nvm_req_wdata;
          m_busy = 1'b0; m_ctl[1:0] = 2'b00;
        end else begin
          pend = 1'b1; p_addr = nvm_req_addr; p_cnt = 1 + int'($urandom % 3);
        end
      end
      if (ctl_wr_en && !cur_busy) begin
        if (ctl_wr_data[1:0] == 2'b10 || (ctl_wr_data[1:0] == 2'b11 && !ctl_wr_data[5])) begin
          m_ctl = ctl_wr_data; m_busy = 1'b1; m_idx = '0; m_addr = ctl_wr_data[15:8];
          m_op = (ctl_wr_data[1:0] == 2'b11) ? 0 : (ctl_wr_data[5] ? 2 : 1);
        end else begin
          m_ctl = {ctl_wr_data[15:2], 2'b00};
        end
      end
      if (shd_wr_en && !cur_busy) m_shd[shd_wr_addr] = shd_wr_data;
    end
    shd_rd_addr = probe_on ? probe_addr : sweep;
    sweep = sweep + 8'd37;
  end

  task automatic write_ctl(input logic [15:0] v);
    @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = v;
    @(negedge clk); ctl_wr_en = 1'b0;
  endtask

  task automatic write_shd(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); shd_wr_en = 1'b1; shd_wr_addr = a; shd_wr_data = d;
    @(negedge clk); shd_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk); #3;
      if (!busy) break;
    end
  endtask

  task automatic probe(input logic [7:0] a, input logic [7:0] exp, input string tag);
    probe_addr = a; probe_on = 1'b1;
    @(negedge clk); @(negedge clk); #3;
    check(tag, shd_rd_data, exp);
    probe_on = 1'b0;
  endtask

  logic [7:0] good_sum;

  initial begin
    for (int i = 0; i < 256; i++) nvm_mem[i] = 8'($urandom);
    nvm_mem[118] = sum_range();
    repeat (4) @(negedge clk);
    #3 check("R1 busy during reset", busy, 1);
    check("R3 checksum cleared by reset", cks_calc, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (20) @(negedge clk);
    write_ctl(16'h1202);                       // R8: ignored, upload in progress
    write_shd(8'h10, ~nvm_mem[8'h10]);         // R10: ignored while busy
    wait_idle();
    check("R1 boot upload done", busy, 0);
    check("R3 boot checksum pass", cks_ok, 1);
    check("R8 control unchanged after busy write", ctl_rd_data, 16'h0000);
    probe(8'h10, nvm_mem[8'h10], "R10 busy shadow write dropped");

    write_shd(8'h05, 8'hA5);
    probe(8'h05, 8'hA5, "R10 idle shadow write");
    write_ctl(16'h0522);
    wait_idle();
    check("R5 store byte written", nvm_mem[5], 8'hA5);
    check("R7 command bits cleared", ctl_rd_data, 16'h0520);

    write_shd(8'h07, ~nvm_mem[7]);
    write_ctl(16'h0702);
    wait_idle();
    probe(8'h07, nvm_mem[7], "R4 single read restores byte");

    write_ctl(16'h0901);
    #3 check("R9 code 01 starts nothing", busy, 0);
    check("R9 code 01 stored cleared", ctl_rd_data, 16'h0900);
    write_ctl(16'h0923);
    #3 check("R9 reload with dir set starts nothing", busy, 0);
    check("R9 stored value", ctl_rd_data, 16'h0920);

    write_shd(8'd118, nvm_mem[118] ^ 8'h01);
    write_ctl(16'h7622);
    wait_idle();
    write_shd(8'h30, ~nvm_mem[8'h30]);
    write_ctl(16'h0003);
    write_shd(8'h20, ~nvm_mem[8'h20]);         // R10: ignored while reloading
    wait_idle();
    good_sum = sum_range();
    check("R6 reload detects mismatch", cks_ok, 0);
    check("R6 reload checksum value", cks_calc, good_sum);
    probe(8'h30, nvm_mem[8'h30], "R10 volatile change lost on reload");
    probe(8'h20, nvm_mem[8'h20], "R10 write during reload dropped");

    write_shd(8'd118, good_sum);
    write_ctl(16'h7622);
    wait_idle();
    write_ctl(16'h0003);
    wait_idle();
    check("R6 reload passes after repair", cks_ok, 1);
    check("R2 reference byte shadowed", nvm_mem[118], good_sum);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule